// File: doc/BRIEF.md
# Banked Per-Channel DMA Control Register File

This block is the software-facing register front end of a twenty-channel DMA controller. Software reaches it through a small word-addressed read/write bus. Instead of giving every channel its own address range, the block holds one channel-select register. Six per-channel registers sit behind a shared window, and each access to that window goes to whichever channel is selected. Each channel keeps its own control bits, cause enables, pending causes, descriptor ring base and descriptor ring length. It also keeps an internal ring index that the descriptor engine advances. A global register gates each channel's interrupt line.

Toward the data path, the block drives a per-channel run enable, a one-cycle channel reset pulse and a per-channel interrupt line. From the data path it takes an activity flag, six cause-set pulses and a descriptor-advance pulse for each channel. Each channel has a two-state machine, `CH_RUN` and `CH_RESET`. The transition `CH_RUN -> CH_RESET` happens on a control write with bit 1 set. The transition `CH_RESET -> CH_RUN` always happens after one clock. A reset write arriving while the channel is in `CH_RESET` does not extend the pulse. The bus has no wait states. Read data is registered and appears one clock after the read request.

Top module: `dmarf_top`

## Requirements
- R1: Word 0 is an 8-bit channel-select register (read/write, reset 0). Per-channel words 2 to 7 access the channel whose number equals the stored value.
- R2: In control word 2, bit 0 is the run enable. It drives `ch_enable[n]` from the clock after the write. A read of bit 0 returns the enable OR `ch_active[n]`, so a channel that is still draining reads as on.
- R3: Writing control bit 1 as 1 in `CH_RUN` raises `ch_reset[n]` for exactly one clock. A control read during that clock returns bit 1 as 1; a later read returns 0.
- R4: The reset clock zeroes the channel's pending causes and its ring index, and drops any cause set in that clock. Base, length, cause enables and run enable keep their values.
- R5: Word 1 bit n is the global interrupt enable of channel n (reset 0). While it is 0, `ch_irq[n]` is 0.
- R6: Word 3 holds the cause enables in bits 1 to 6 (reset 0). `ch_irq[n]` is the OR, over the six causes, of pending AND enabled, ANDed with the global bit.
- R7: Word 4 holds the pending causes in bits 1 to 6. A pulse on `cause_set[n*6+k]` sets bit k+1. Writing 1 to a bit clears it. When a set and a clear of the same bit fall in the same clock, the bit stays set.
- R8: Word 5 is the 32-bit descriptor base (reset 0). Word 6 is the 8-bit descriptor ring length (reset 25).
- R9: Word 7 is a read-only ring index (reset 0). It advances on `desc_step[n]` and returns to 0 when the next value would reach the length. Writes to word 7 are ignored.
- R10: While the select value is 20 or more, reads of words 2 to 7 return 0 and writes to them change no channel.
- R11: `bus_rdata` loads on the clock of a read request and holds otherwise. All unassigned bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_active | input | 20 | Per-channel data mover still busy |
| cause_set | input | 120 | Per-channel cause-set pulses, six per channel |
| desc_step | input | 20 | Per-channel descriptor advance pulse |
| ch_enable | output | 20 | Per-channel run enable |
| ch_reset | output | 20 | Per-channel one-clock reset pulse |
| ch_irq | output | 20 | Per-channel interrupt line |

## Verification
Two functions can act on the same pending bit in the same clock: a hardware cause pulse and a software write-one-to-clear. A third can also join in: the channel reset clock, which overrides both. The bench provokes the first collision directly, by clearing all causes of the selected channel in the clock where a cause pulse arrives. It then judges the readback against the rule that the set wins. Random traffic also lands cause pulses and ring advances inside reset clocks. A bench model computes the expected status and index from R4 and R7 on every cycle, and compares them through reads and the interrupt lines.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    typedef enum logic [2:0] {
        RA_SEL  = 3'd0,
        RA_GIE  = 3'd1,
        RA_CTRL = 3'd2,
        RA_IE   = 3'd3,
        RA_STAT = 3'd4,
        RA_BASE = 3'd5,
        RA_CNT  = 3'd6,
        RA_IDX  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        CH_RUN   = 1'b0,
        CH_RESET = 1'b1
    } ch_state_e;

endpackage

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
#(
    parameter int DW      = 32,
    parameter int NCAUSE  = 6,
    parameter int CNT_W   = 8,
    parameter int CNT_RST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hit,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              ch_active,
    input  logic [NCAUSE-1:0] cause_set,
    input  logic              desc_step,
    output logic [DW-1:0]     rd_word,
    output logic              ch_en,
    output logic              ch_rst,
    output logic [NCAUSE-1:0] stat_o,
    output logic              pend
);
    localparam int CLSB = 1;

    ch_state_e         state_q, state_d;
    logic              en_q;
    logic [NCAUSE-1:0] ie_q, st_q, clr_mask;
    logic [DW-1:0]     base_q;
    logic [CNT_W-1:0]  cnt_q, idx_q;
    logic [CNT_W:0]    idx_inc;
    logic              wr, wr_ctrl, wr_ie, wr_st, wr_base, wr_cnt;

    assign wr      = sel_hit && bus_we;
    assign wr_ctrl = wr && (bus_addr == RA_CTRL);
    assign wr_ie   = wr && (bus_addr == RA_IE);
    assign wr_st   = wr && (bus_addr == RA_STAT);
    assign wr_base = wr && (bus_addr == RA_BASE);
    assign wr_cnt  = wr && (bus_addr == RA_CNT);

    assign clr_mask = wr_st ? bus_wdata[CLSB +: NCAUSE] : '0;
    assign idx_inc  = {1'b0, idx_q} + (CNT_W+1)'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_RUN:   if (wr_ctrl && bus_wdata[1]) state_d = CH_RESET;
            CH_RESET: state_d = CH_RUN;
        endcase
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= '0;
            st_q   <= '0;
            base_q <= '0;
            cnt_q  <= CNT_W'(CNT_RST);
            idx_q  <= '0;
        end else begin
            if (wr_ctrl) en_q   <= bus_wdata[0];
            if (wr_ie)   ie_q   <= bus_wdata[CLSB +: NCAUSE];
            if (wr_base) base_q <= bus_wdata;
            if (wr_cnt)  cnt_q  <= bus_wdata[CNT_W-1:0];
            if (state_q == CH_RESET) begin
                st_q  <= '0;
                idx_q <= '0;
            end else begin
                st_q <= (st_q & ~clr_mask) | cause_set;
                if (desc_step)
                    idx_q <= (idx_inc >= {1'b0, cnt_q}) ? '0 : idx_inc[CNT_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        ch_rst = (state_q == CH_RESET);
        ch_en  = en_q;
        stat_o = st_q;
        pend   = |(st_q & ie_q);
        unique case (bus_addr)
            RA_CTRL: rd_word = DW'({ch_rst, en_q | ch_active});
            RA_IE:   rd_word = DW'({ie_q, 1'b0});
            RA_STAT: rd_word = DW'({st_q, 1'b0});
            RA_BASE: rd_word = base_q;
            RA_CNT:  rd_word = DW'(cnt_q);
            RA_IDX:  rd_word = DW'(idx_q);
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/dmarf_irq_gate.sv
module dmarf_irq_gate #(
    parameter int NUM_CH = 20
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] gie,
    output logic [NUM_CH-1:0] irq
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
        assign irq[g] = pend[g] & gie[g];
    end
endmodule

// File: rtl/dmarf_top.sv
module dmarf_top
    import dmarf_pkg::*;
#(
    parameter int NUM_CH  = 20,
    parameter int NCAUSE  = 6,
    parameter int DW      = 32,
    parameter int SEL_W   = 8,
    parameter int CNT_W   = 8,
    parameter int CNT_RST = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [2:0]               bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NUM_CH-1:0]        ch_active,
    input  logic [NUM_CH*NCAUSE-1:0] cause_set,
    input  logic [NUM_CH-1:0]        desc_step,
    output logic [NUM_CH-1:0]        ch_enable,
    output logic [NUM_CH-1:0]        ch_reset,
    output logic [NUM_CH-1:0]        ch_irq
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [SEL_W-1:0]         sel_q;
    logic [NUM_CH-1:0]        gie_q, hit, pend;
    logic                     sel_ok;
    logic [DW-1:0]            rd_words [NUM_CH];
    logic [DW-1:0]            chan_rd, rd_mux;
    logic [NUM_CH*NCAUSE-1:0] st_all;

    assign sel_ok = (sel_q < SEL_W'(NUM_CH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            gie_q <= '0;
        end else if (bus_en && bus_we) begin
            if (bus_addr == RA_SEL) sel_q <= bus_wdata[SEL_W-1:0];
            if (bus_addr == RA_GIE) gie_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit[g] = bus_en && sel_ok && (sel_q == SEL_W'(g));
        dmarf_chan #(
            .DW(DW), .NCAUSE(NCAUSE), .CNT_W(CNT_W), .CNT_RST(CNT_RST)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_hit   (hit[g]),
            .bus_we    (bus_we),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .ch_active (ch_active[g]),
            .cause_set (cause_set[g*NCAUSE +: NCAUSE]),
            .desc_step (desc_step[g]),
            .rd_word   (rd_words[g]),
            .ch_en     (ch_enable[g]),
            .ch_rst    (ch_reset[g]),
            .stat_o    (st_all[g*NCAUSE +: NCAUSE]),
            .pend      (pend[g])
        );
    end

    dmarf_irq_gate #(.NUM_CH(NUM_CH)) u_gate (
        .pend (pend),
        .gie  (gie_q),
        .irq  (ch_irq)
    );

    assign chan_rd = sel_ok ? rd_words[sel_q[CH_W-1:0]] : '0;

    always_comb begin
        unique case (bus_addr)
            RA_SEL:  rd_mux = DW'(sel_q);
            RA_GIE:  rd_mux = DW'(gie_q);
            default: rd_mux = chan_rd;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/dmarf_check.sv
module dmarf_check #(
    parameter int NUM_CH = 20,
    parameter int NCAUSE = 6,
    parameter int DW     = 32,
    parameter int SEL_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_en,
    input logic                     bus_we,
    input logic [2:0]               bus_addr,
    input logic [DW-1:0]            bus_rdata,
    input logic [SEL_W-1:0]         sel_q,
    input logic [NUM_CH-1:0]        gie_q,
    input logic [NUM_CH-1:0]        ch_enable,
    input logic [NUM_CH-1:0]        ch_reset,
    input logic [NUM_CH-1:0]        ch_irq,
    input logic [NUM_CH*NCAUSE-1:0] cause_set,
    input logic [NUM_CH*NCAUSE-1:0] st_all
);
    a_r5_gie_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq & ~gie_q) == '0);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_reset & $past(ch_reset)) == '0);

    a_r2_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == 3'd2) |=> $stable(ch_enable));

    a_r10_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && sel_q >= SEL_W'(NUM_CH) && bus_addr >= 3'd2) |=> bus_rdata == '0);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> $stable(bus_rdata));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
        a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ch_reset[g] |=> st_all[g*NCAUSE +: NCAUSE] == '0);

        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (|cause_set[g*NCAUSE +: NCAUSE] && !ch_reset[g]) |=>
            ((st_all[g*NCAUSE +: NCAUSE] & $past(cause_set[g*NCAUSE +: NCAUSE]))
              == $past(cause_set[g*NCAUSE +: NCAUSE])));
    end
endmodule

bind dmarf_top dmarf_check #(
    .NUM_CH(NUM_CH), .NCAUSE(NCAUSE), .DW(DW), .SEL_W(SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sel_q     (sel_q),
    .gie_q     (gie_q),
    .ch_enable (ch_enable),
    .ch_reset  (ch_reset),
    .ch_irq    (ch_irq),
    .cause_set (cause_set),
    .st_all    (st_all)
);

// File: tb/test_dmarf_top.sv
`timescale 1ns/1ps
module test_dmarf_top;
    localparam int NCH = 20;
    localparam int NC  = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_en, bus_we;
    logic [2:0]    bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NCH-1:0]    ch_active, desc_step, ch_enable, ch_reset, ch_irq;
    logic [NCH*NC-1:0] cause_set;

    always #5 clk = ~clk;

    dmarf_top i_dmarf_top (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_active(ch_active), .cause_set(cause_set), .desc_step(desc_step),
        .ch_enable(ch_enable), .ch_reset(ch_reset), .ch_irq(ch_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [7:0]     m_sel;
    logic [NCH-1:0] m_gie, m_en, m_rst;
    logic [NC-1:0]  m_ie [NCH];
    logic [NC-1:0]  m_st [NCH];
    logic [31:0]    m_base [NCH];
    logic [7:0]     m_cnt [NCH];
    logic [7:0]     m_idx [NCH];
    logic [31:0]    m_rd;
    string          m_tag;

    function automatic logic [NCH-1:0] f_irq();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = m_gie[i] && |(m_st[i] & m_ie[i]);
        return r;
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a, input logic [NCH-1:0] act);
        int n;
        n = m_sel;
        if (a == 3'd0) return {24'b0, m_sel};
        if (a == 3'd1) return {12'b0, m_gie};
        if (m_sel >= NCH) return 32'h0;
        case (a)
            3'd2:    return {30'b0, m_rst[n], m_en[n] | act[n]};
            3'd3:    return {25'b0, m_ie[n], 1'b0};
            3'd4:    return {25'b0, m_st[n], 1'b0};
            3'd5:    return m_base[n];
            3'd6:    return {24'b0, m_cnt[n]};
            default: return {24'b0, m_idx[n]};
        endcase
    endfunction

    function automatic string f_tag(input logic [2:0] a);
        if (a >= 3'd2 && m_sel >= NCH) return "R10";
        case (a)
            3'd0: return "R1";
            3'd1: return "R5";
            3'd2: return "R2/R3";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd7: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = '0; m_gie = '0; m_en = '0; m_rst = '0; m_rd = '0;
        for (int i = 0; i < NCH; i++) begin
            m_ie[i] = '0; m_st[i] = '0; m_base[i] = '0; m_cnt[i] = 8'd25; m_idx[i] = '0;
        end
    endtask

    task automatic cyc(input logic en, input logic we, input logic [2:0] a,
                       input logic [31:0] wd, input logic [NCH-1:0] act,
                       input logic [NCH*NC-1:0] cs, input logic [NCH-1:0] stp);
        logic [NCH-1:0] nrst;
        logic [7:0]     inc;
        int n;
        bit  wr;
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
        ch_active = act; cause_set = cs; desc_step = stp;
        if (en && !we) begin
            m_rd  = f_read(a, act);
            m_tag = f_tag(a);
        end else m_tag = "R11";
        n  = m_sel;
        wr = en && we && (m_sel < NCH);
        nrst = '0;
        for (int i = 0; i < NCH; i++) begin
            if (m_rst[i]) begin
                m_st[i]  = '0;
                m_idx[i] = '0;
            end else begin
                if (wr && a == 3'd4 && i == n) m_st[i] = m_st[i] & ~wd[6:1];
                m_st[i] = m_st[i] | cs[i*NC +: NC];
                if (stp[i]) begin
                    inc = m_idx[i] + 8'd1;
                    m_idx[i] = ({1'b0, inc} >= {1'b0, m_cnt[i]}) ? 8'd0 : inc;
                end
            end
        end
        if (wr) begin
            case (a)
                3'd2: begin m_en[n] = wd[0]; nrst[n] = wd[1] && !m_rst[n]; end
                3'd3: m_ie[n]   = wd[6:1];
                3'd5: m_base[n] = wd;
                3'd6: m_cnt[n]  = wd[7:0];
                default: ;
            endcase
        end
        if (en && we && a == 3'd0) m_sel = wd[7:0];
        if (en && we && a == 3'd1) m_gie = wd[NCH-1:0];
        m_rst = nrst;
        @(posedge clk);
        #1;
        chk("R2", 32'(ch_enable), 32'(m_en));
        chk("R3", 32'(ch_reset), 32'(m_rst));
        chk("R6", 32'(ch_irq), 32'(f_irq()));
        chk(m_tag, bus_rdata, m_rd);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] wd);
        cyc(1'b1, 1'b1, a, wd, '0, '0, '0);
    endtask

    task automatic rd_reg(input logic [2:0] a);
        cyc(1'b1, 1'b0, a, '0, '0, '0, '0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NCH*NC-1:0] cs;
        logic [NCH-1:0]    stp;
        logic [2:0]        a;
        logic [31:0]       wd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        ch_active = '0; cause_set = '0; desc_step = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // reset state
        chk("R2 reset", 32'(ch_enable), 32'h0);
        chk("R3 reset", 32'(ch_reset), 32'h0);
        chk("R5 reset", 32'(ch_irq), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd_reg(3'd6);                       // R8 default length 25
        chk("R8 default", bus_rdata, 32'd25);

        // R7 set and clear in the same clock
        wr_reg(3'd0, 32'd3);
        wr_reg(3'd3, 32'h7E);
        wr_reg(3'd1, 32'h8);
        cs = '0; cs[3*NC + 0] = 1'b1; cs[3*NC + 2] = 1'b1;
        cyc(1'b1, 1'b0, 3'd0, '0, '0, cs, '0);
        cs = '0; cs[3*NC + 0] = 1'b1;
        cyc(1'b1, 1'b1, 3'd4, 32'h7E, '0, cs, '0);
        rd_reg(3'd4);
        chk("R7 set wins", bus_rdata, 32'h2);

        // R3/R4 reset pulse, readback, preserved fields
        wr_reg(3'd5, 32'hCAFE_0040);
        cyc(1'b1, 1'b0, 3'd0, '0, '0, '0, 4'b1000);
        wr_reg(3'd2, 32'h3);
        rd_reg(3'd2);
        chk("R3 bit1 during pulse", bus_rdata & 32'h2, 32'h2);
        rd_reg(3'd2);
        chk("R3 bit1 after pulse", bus_rdata & 32'h2, 32'h0);
        rd_reg(3'd4);
        chk("R4 status cleared", bus_rdata, 32'h0);
        rd_reg(3'd7);
        chk("R4 index cleared", bus_rdata, 32'h0);
        rd_reg(3'd5);
        chk("R4 base kept", bus_rdata, 32'hCAFE_0040);

        // R10 invalid select
        wr_reg(3'd0, 32'd22);
        wr_reg(3'd5, 32'h1234_5678);
        rd_reg(3'd5);
        chk("R10 invalid read", bus_rdata, 32'h0);
        wr_reg(3'd0, 32'd3);
        rd_reg(3'd5);
        chk("R10 write ignored", bus_rdata, 32'hCAFE_0040);

        // R9 ring wrap with a short ring
        wr_reg(3'd6, 32'd2);
        wr_reg(3'd7, 32'hFF);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 3'd0, '0, '0, '0, 4'b1000);
        rd_reg(3'd7);
        chk("R9 wrap", bus_rdata, 32'd1);

        // constrained random traffic
        for (int t = 0; t < 3000; t++) begin
            a  = 3'($urandom_range(0, 7));
            wd = $urandom;
            if (a == 3'd0) wd = $urandom_range(0, 22);
            if (a == 3'd2) wd = (wd & ~32'h2) | (($urandom_range(0, 3) == 0) ? 32'h2 : 32'h0);
            if (a == 3'd6) wd = $urandom_range(0, 6);
            cs = '0;
            for (int b = 0; b < NCH*NC; b++) cs[b] = ($urandom_range(0, 9) == 0);
            for (int b = 0; b < NCH; b++) stp[b] = ($urandom_range(0, 3) == 0);
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, wd,
                NCH'($urandom), cs, stp);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule